// File: doc/BRIEF.md
# Flash Ready/Busy Pin Configurator

This block owns the single status pin that a NOR flash controller presents to the host. After reset the pin reports busy as a level: it is low while the internal write state machine works, and high when that machine is idle or suspended. The host can turn the pin into an interrupt source by sending a configuration command. It then rests high and drops low for a fixed 250 ns whenever an enabled erase or program completion occurs.

Commands arrive as decoded command-bus writes. A configuration opcode is followed by a data write whose two low bits select the mode. The block checks that sequence and keeps the selected mode until reset or the next valid configuration. Misuse of the command sets the program-error and erase-error status bits together. These bits are sticky until a clear-status strobe.

Top module: `sts_pin_cfg`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, the mode is level mode, sts_pin equals the level-mode value and both error outputs are 0.
- R2: In level mode sts_pin is 0 exactly when wsm_busy is 1 and wsm_susp is 0. Otherwise it is 1. The pin follows these inputs in the same cycle.
- R3: A write of opcode 0xB8 followed by a data write whose bits [7:2] are zero loads mode code = data[1:0]. The new mode applies from the cycle after the data write. Writes of other values are ignored and do not disturb the sequence.
- R4: Mode code bit 0 enables the pulse on erase_done and bit 1 enables the pulse on prog_done. In a pulse mode sts_pin rests at 1, and a completion event whose bit is clear leaves it at 1.
- R5: An enabled event sampled at a clock edge drives sts_pin to 0 for exactly ceil(250 ns × clock frequency) cycles, starting the cycle after that edge. This is 32 cycles at 125 MHz.
- R6: An enabled event that occurs while a pulse is active restarts the count, so the pin stays low a full width after the latest event.
- R7: A configuration data write with any of bits [7:2] set raises both error bits and leaves the mode unchanged.
- R8: A configuration data write made while wsm_busy or wsm_susp is 1 raises both error bits and leaves the mode unchanged.
- R9: A write of the retired opcode 0x60 raises both error bits in the following cycle.
- R10: The error bits stay set until a cycle with clr_status high, which clears them at that edge. If an error is raised in the same cycle, setting wins.
- R11: Loading code 00 returns the pin to level mode at once and cancels any pulse in progress.
- R12: Driving rst_n low restores level mode and clears both error bits, whatever the mode was before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr | input | 1 | Command-bus write strobe, one cycle per write |
| cmd_data | input | 8 | Data carried by the command-bus write |
| wsm_busy | input | 1 | Write state machine is busy |
| wsm_susp | input | 1 | Write state machine is suspended |
| erase_done | input | 1 | Single-cycle erase completion event |
| prog_done | input | 1 | Single-cycle program completion event |
| clr_status | input | 1 | Clears the sticky error bits |
| sts_pin | output | 1 | Status pin level |
| err_prog | output | 1 | Program-error status bit |
| err_erase | output | 1 | Erase-error status bit |

## Verification
The case that is hardest to reach from the ports is a retrigger: a second enabled completion has to land partway through a pulse that is already running. The bench counts low samples cycle by cycle from the first event. It fires the second event exactly on the tenth low sample, which makes the expected total length a plain sum. A second hard case is a pulse that is cut short by a return to level mode, because the two-write configuration sequence must finish while the pulse is still in progress. The bench starts the pulse first, then issues the two writes, and checks that the pin is high right after the data write.

// File: rtl/sts_pkg.sv
package sts_pkg;

  typedef logic [1:0] sts_code_t;

  localparam sts_code_t CODE_LEVEL = 2'b00;

  // Cycles covering pulse_ns at clk_khz, rounded up.
  function automatic int pulse_cycles(input int clk_khz, input int pulse_ns);
    longint prod;
    prod = longint'(clk_khz) * longint'(pulse_ns);
    return int'((prod + 64'd999_999) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/sts_cmd_seq.sv
module sts_cmd_seq
  import sts_pkg::*;
#(
  parameter logic [7:0] CFG_OPC = 8'hB8,
  parameter logic [7:0] OLD_OPC = 8'h60
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      cmd_wr,
  input  logic [7:0] cmd_data,
  input  logic      wsm_busy,
  input  logic      wsm_susp,
  input  logic      clr_status,
  output sts_code_t mode,
  output logic      err_prog,
  output logic      err_erase
);

  logic      armed;
  logic      data_cyc;
  logic      code_bad;
  logic      wsm_blocked;
  logic      load_ok;
  logic      err_set;

  assign data_cyc    = cmd_wr && armed;
  assign code_bad    = cmd_data[7:2] != 6'd0;
  assign wsm_blocked = wsm_busy || wsm_susp;
  assign load_ok     = data_cyc && !code_bad && !wsm_blocked;
  assign err_set     = (data_cyc && (code_bad || wsm_blocked))
                     || (cmd_wr && !armed && cmd_data == OLD_OPC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      mode  <= CODE_LEVEL;
    end else begin
      if (cmd_wr) armed <= !armed && cmd_data == CFG_OPC;
      if (load_ok) mode <= cmd_data[1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_prog  <= 1'b0;
      err_erase <= 1'b0;
    end else if (err_set) begin
      err_prog  <= 1'b1;
      err_erase <= 1'b1;
    end else if (clr_status) begin
      err_prog  <= 1'b0;
      err_erase <= 1'b0;
    end
  end

  // R7
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && code_bad) |=> (err_prog && err_erase && $stable(mode)));

  // R8
  blocked_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_cyc && wsm_blocked) |=> (err_prog && err_erase && $stable(mode)));

  // R10
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_status && !err_set) |=> (!err_prog && !err_erase));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_prog && !clr_status) |=> err_prog);

endmodule

// File: rtl/sts_pulse_timer.sv
module sts_pulse_timer #(
  parameter int PW = 32,
  localparam int CW = $clog2(PW + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic trig,
  output logic low
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (hold)          cnt <= '0;
    else if (trig)          cnt <= CW'(PW);
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign low = cnt != '0;

  // R6
  retrig_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !hold) |=> (cnt == CW'(PW)));

  // R5
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !trig && !hold) |=> (cnt == $past(cnt) - 1'b1));

  // R11
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> !low);

endmodule

// File: rtl/sts_pin_cfg.sv
module sts_pin_cfg
  import sts_pkg::*;
#(
  parameter int         CLK_KHZ  = 125_000,
  parameter int         PULSE_NS = 250,
  parameter logic [7:0] CFG_OPC  = 8'hB8,
  parameter logic [7:0] OLD_OPC  = 8'h60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_wr,
  input  logic [7:0] cmd_data,
  input  logic       wsm_busy,
  input  logic       wsm_susp,
  input  logic       erase_done,
  input  logic       prog_done,
  input  logic       clr_status,
  output logic       sts_pin,
  output logic       err_prog,
  output logic       err_erase
);

  localparam int PW = pulse_cycles(CLK_KHZ, PULSE_NS);

  sts_code_t mode;
  logic      level_mode;
  logic      pulse_trig;
  logic      pulse_low;
  logic      level_val;

  sts_cmd_seq #(.CFG_OPC(CFG_OPC), .OLD_OPC(OLD_OPC)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .cmd_data  (cmd_data),
    .wsm_busy  (wsm_busy),
    .wsm_susp  (wsm_susp),
    .clr_status(clr_status),
    .mode      (mode),
    .err_prog  (err_prog),
    .err_erase (err_erase)
  );

  assign level_mode = mode == CODE_LEVEL;
  assign pulse_trig = (erase_done && mode[0]) || (prog_done && mode[1]);
  assign level_val  = !(wsm_busy && !wsm_susp);

  sts_pulse_timer #(.PW(PW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (level_mode),
    .trig (pulse_trig),
    .low  (pulse_low)
  );

  assign sts_pin = level_mode ? level_val : !pulse_low;

  // R2
  level_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level_mode |-> (sts_pin == !(wsm_busy && !wsm_susp)));

  // R4
  pulse_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!level_mode && $past(!level_mode) && $past(sts_pin) && !$past(pulse_trig)) |-> sts_pin);

endmodule

// File: tb/sim_sts_pin_cfg.sv
module sim_sts_pin_cfg;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       wsm_busy = 1'b0;
  logic       wsm_susp = 1'b0;
  logic       erase_done = 1'b0;
  logic       prog_done = 1'b0;
  logic       clr_status = 1'b0;
  logic       sts_pin;
  logic       err_prog;
  logic       err_erase;

  int n_chk = 0;
  int n_bad = 0;

  // 250 ns at an 8 ns period, rounded up
  localparam int PER_NS = 8;
  localparam int EXP_PW = (250 + PER_NS - 1) / PER_NS;

  always #4 clk = ~clk;

  sts_pin_cfg u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .wsm_busy(wsm_busy), .wsm_susp(wsm_susp), .erase_done(erase_done),
    .prog_done(prog_done), .clr_status(clr_status), .sts_pin(sts_pin),
    .err_prog(err_prog), .err_erase(err_erase)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); cmd_wr = 1'b1; cmd_data = d;
    @(negedge clk); cmd_wr = 1'b0; cmd_data = 8'h00;
  endtask

  task automatic set_mode(input logic [1:0] c);
    wr(8'hB8); wr({6'd0, c});
  endtask

  task automatic clear_err();
    @(negedge clk); clr_status = 1'b1;
    @(negedge clk); clr_status = 1'b0;
  endtask

  // pulse an event and count the low cycles that follow
  task automatic fire(input bit e, input bit p, output int lows);
    @(negedge clk); erase_done = e; prog_done = p;
    @(negedge clk); erase_done = 1'b0; prog_done = 1'b0;
    lows = 0;
    while (sts_pin == 1'b0 && lows < 200) begin
      lows++;
      @(negedge clk);
    end
  endtask

  task automatic errs_both(input string req, input bit exp);
    check(err_prog == exp && err_erase == exp, req, {err_prog, err_erase}, {exp, exp});
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    int lows;
    wsm_busy = 1'b1;
    #1;
    // R1 during reset
    check(sts_pin == 1'b0, "R1 pin busy in reset", sts_pin, 0);
    errs_both("R1 errors in reset", 1'b0);
    wsm_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(sts_pin == 1'b1, "R1 pin after reset", sts_pin, 1);
    errs_both("R1 errors after reset", 1'b0);

    // R2 level mode sweep
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); wsm_busy = k[0]; wsm_susp = k[1]; #1;
      check(sts_pin == !(k == 1), "R2 level pin", sts_pin, !(k == 1));
    end
    wsm_busy = 1'b0; wsm_susp = 1'b0;

    // R2: events do nothing in level mode
    fire(1'b1, 1'b1, lows);
    check(lows == 0, "R2 no pulse in level mode", lows, 0);

    // R3 R4 R5: all codes x all event mixes
    for (int c = 1; c < 4; c++) begin
      set_mode(c[1:0]);
      check(sts_pin == 1'b1, "R4 pulse mode rests high", sts_pin, 1);
      for (int ev = 0; ev < 4; ev++) begin
        int exp;
        exp = ((ev[0] && c[0]) || (ev[1] && c[1])) ? EXP_PW : 0;
        fire(ev[0], ev[1], lows);
        check(lows == exp, $sformatf("R5 code %0d ev %0d width", c, ev), lows, exp);
      end
    end

    // R3: an unrelated write between sequences has no effect, then data
    set_mode(2'b01);
    wr(8'h20);
    fire(1'b0, 1'b1, lows);
    check(lows == 0, "R3 unrelated write ignored", lows, 0);
    errs_both("R3 no error on valid load", 1'b0);

    // R6 retrigger at the tenth low cycle
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    lows = 0;
    while (sts_pin == 1'b0 && lows < 200) begin
      lows++;
      erase_done = (lows == 10);
      @(negedge clk);
    end
    erase_done = 1'b0;
    check(lows == 10 + EXP_PW, "R6 retrigger width", lows, 10 + EXP_PW);

    // R11: return to level aborts a pulse
    @(negedge clk); erase_done = 1'b1;
    @(negedge clk); erase_done = 1'b0;
    check(sts_pin == 1'b0, "R11 pulse started", sts_pin, 0);
    set_mode(2'b00);
    check(sts_pin == 1'b1, "R11 level after abort", sts_pin, 1);
    wsm_busy = 1'b1; #1;
    check(sts_pin == 1'b0, "R11 level tracks busy", sts_pin, 0);
    wsm_busy = 1'b0;

    // R7: every invalid code sets both errors, mode kept (level)
    for (int v = 4; v < 256; v++) begin
      wr(8'hB8); wr(v[7:0]);
      errs_both($sformatf("R7 bad code %0d", v), 1'b1);
      clear_err();
    end
    fire(1'b1, 1'b1, lows);
    check(lows == 0, "R7 mode unchanged", lows, 0);

    // R8: busy or suspended rejects
    for (int k = 1; k < 4; k++) begin
      wr(8'hB8);
      @(negedge clk); wsm_busy = k[0]; wsm_susp = k[1];
      cmd_wr = 1'b1; cmd_data = 8'h03;
      @(negedge clk); cmd_wr = 1'b0; wsm_busy = 1'b0; wsm_susp = 1'b0;
      errs_both("R8 blocked config error", 1'b1);
      clear_err();
      fire(1'b1, 1'b1, lows);
      check(lows == 0, "R8 mode unchanged", lows, 0);
    end

    // R9 retired opcode, R10 sticky then clear
    wr(8'h60);
    errs_both("R9 retired opcode", 1'b1);
    repeat (5) @(negedge clk);
    errs_both("R10 sticky", 1'b1);
    clear_err();
    errs_both("R10 cleared", 1'b0);

    // R10 set wins over clear in the same cycle
    @(negedge clk); cmd_wr = 1'b1; cmd_data = 8'h60; clr_status = 1'b1;
    @(negedge clk); cmd_wr = 1'b0; clr_status = 1'b0;
    errs_both("R10 set beats clear", 1'b1);

    // R12 reset from pulse mode with errors set
    set_mode(2'b11);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    errs_both("R12 errors cleared", 1'b0);
    wsm_busy = 1'b1; #1;
    check(sts_pin == 1'b0, "R12 level mode restored", sts_pin, 0);
    wsm_busy = 1'b0;

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule